// File: doc/BRIEF.md
# Punched-Card ROM Pattern Loader

This block turns a stream of 80-column text records into writes on a 2048-word by 8-bit memory port. Characters arrive one per cycle when `ch_valid` is high. A cycle with `ch_valid` and `ch_eor` both high marks the end of a record. The character's position inside the record, counted from column 1, decides what the character means. The block keeps no buffer: it decodes each character as it arrives and issues a write as soon as the last character of a word has been taken.

The `fmt_multi` input picks one of two record layouts and must stay constant for the length of a record.

- **Block layout** (`fmt_multi` = 0): a decimal start address is followed by eight words written as P/N characters. The words go to consecutive addresses.
- **Multi-entry layout** (`fmt_multi` = 1): the record carries four groups. Each group holds a decimal address, a binary word and an octal copy of that word, and the octal copy is used to cross-check the binary word.

Three sticky flags report problems. One flags a malformed character. One flags an address that is out of range or misaligned. One flags an octal copy that does not match its word. A running write counter lets the loading side confirm how many words were stored.

Top module: `pcl_loader`

## Requirements
- R1: After reset `wr_en`, `wr_count`, `err_char`, `err_range` and `err_octal` are all 0, and the next character is taken as column 1.
- R2: A handshake with `ch_eor` high ends the record, ignores `ch_data` and makes the next character column 1. Characters past column 80 and cycles with `ch_valid` low change nothing.
- R3: In block layout, columns 1 to 5 hold the start address as five ASCII decimal digits, most significant digit first.
- R4: In block layout, word k (k = 0 to 7) occupies columns 7+9k to 14+9k. 'P' is a 1 and 'N' is a 0, and the first column holds bit 7. The word is written to start+k with `wr_en` high in the cycle after the handshake of its last column.
- R5: In block layout, a start address that is not a multiple of 8, or that is above 2040, sets `err_range`, and the record produces no writes.
- R6: In block layout, columns 6, 15, 24, 33, 42, 51, 60, 69 and 78 to 80 may hold any character and have no effect.
- R7: In multi-entry layout, group g (g = 0 to 3) starts at column b = 1+21g. It holds a 4-digit decimal address at b to b+3, a word of ASCII '0'/'1' characters (MSB first) at b+5 to b+12, and a 3-digit octal value at b+14 to b+16. The group is written in the cycle after the handshake of column b+16. All other columns have no effect.
- R8: In multi-entry layout, an octal value that differs from the group's word sets `err_octal` and suppresses that group's write, while later groups of the record are still processed.
- R9: In multi-entry layout, a group address above 2047 sets `err_range` and suppresses that group's write.
- R10: A character that does not belong in its field sets `err_char`, and every later character of the record is discarded up to the end-of-record marker; writes already made stand. The characters that do not belong are a non-digit in an address field, a character other than 'P'/'N' (block) or '0'/'1' (multi) in a word field, and a character other than '0' to '7' in an octal field.
- R11: `wr_en` is high for single cycles only. `wr_count` rises by one with each write and wraps at 2^CNT_W.
- R12: The three error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_multi | input | 1 | 0 = block layout, 1 = multi-entry layout |
| ch_valid | input | 1 | Character or marker present this cycle |
| ch_eor | input | 1 | With ch_valid: end-of-record marker |
| ch_data | input | 8 | ASCII character |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | 8 | Memory write data |
| err_char | output | 1 | Sticky malformed-character flag |
| err_range | output | 1 | Sticky address range/alignment flag |
| err_octal | output | 1 | Sticky octal mismatch flag |
| wr_count | output | CNT_W | Number of writes issued, modulo 2^CNT_W |

## Verification
The hardest case to reach is a fault partway through a record. A malformed character in the fourth block word, or in the second multi-entry group, must leave the earlier writes in place and silence everything after it until the marker arrives. The bench builds whole records as text and then overwrites single columns to plant these faults. It also cuts a record short before its third word, and it stretches one record with idle cycles between characters. A per-character reference model predicts every write and flag cycle by cycle. A separate run of block records drives the narrowed write counter through its wrap.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    localparam int COLS          = 80;
    localparam int WORD_W        = 8;
    localparam int BLK_ADDR_DIG  = 5;
    localparam int BLK_DATA_COL0 = 7;
    localparam int BLK_PITCH     = WORD_W + 1;
    localparam int BLK_WORDS     = 8;
    localparam int MUL_PITCH     = 21;
    localparam int MUL_GROUPS    = 4;
    localparam int MUL_ADDR_DIG  = 4;
    localparam int MUL_WORD_OFF  = MUL_ADDR_DIG + 1;
    localparam int OCT_DIG       = 3;
    localparam int MUL_OCT_OFF   = MUL_WORD_OFF + WORD_W + 1;
    localparam int ACC_W         = 17;
    localparam int OCT_W         = 3 * OCT_DIG;

    typedef enum logic [1:0] {FK_SKIP, FK_ADDR, FK_BITS, FK_OCT} fkind_e;

    typedef struct packed {
        fkind_e     kind;
        logic       first;
        logic       last;
        logic [2:0] idx;
    } colrole_t;

    function automatic colrole_t col_role(input logic multi, input logic [6:0] col);
        colrole_t r;
        int c, off, pos, grp;
        r = '{kind: FK_SKIP, first: 1'b0, last: 1'b0, idx: 3'd0};
        c = int'(col);
        if (c >= 1 && c <= COLS) begin
            if (!multi) begin
                if (c <= BLK_ADDR_DIG) begin
                    r.kind  = FK_ADDR;
                    r.first = (c == 1);
                    r.last  = (c == BLK_ADDR_DIG);
                end else if (c >= BLK_DATA_COL0) begin
                    off = c - BLK_DATA_COL0;
                    pos = off % BLK_PITCH;
                    grp = off / BLK_PITCH;
                    if (grp < BLK_WORDS && pos < WORD_W) begin
                        r.kind  = FK_BITS;
                        r.first = (pos == 0);
                        r.last  = (pos == WORD_W - 1);
                        r.idx   = 3'(grp);
                    end
                end
            end else begin
                off = c - 1;
                pos = off % MUL_PITCH;
                grp = off / MUL_PITCH;
                if (grp < MUL_GROUPS) begin
                    r.idx = 3'(grp);
                    if (pos < MUL_ADDR_DIG) begin
                        r.kind  = FK_ADDR;
                        r.first = (pos == 0);
                        r.last  = (pos == MUL_ADDR_DIG - 1);
                    end else if (pos >= MUL_WORD_OFF && pos < MUL_WORD_OFF + WORD_W) begin
                        r.kind  = FK_BITS;
                        r.first = (pos == MUL_WORD_OFF);
                        r.last  = (pos == MUL_WORD_OFF + WORD_W - 1);
                    end else if (pos >= MUL_OCT_OFF && pos < MUL_OCT_OFF + OCT_DIG) begin
                        r.kind  = FK_OCT;
                        r.first = (pos == MUL_OCT_OFF);
                        r.last  = (pos == MUL_OCT_OFF + OCT_DIG - 1);
                    end
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pcl_chardec.sv
module pcl_chardec (
    input  logic       multi,
    input  logic [7:0] ch,
    output logic       dig_ok,
    output logic [3:0] dig_val,
    output logic       bit_ok,
    output logic       bit_val,
    output logic       oct_ok
);
    always_comb begin
        dig_ok  = (ch >= 8'h30) && (ch <= 8'h39);
        dig_val = ch[3:0];
        oct_ok  = (ch >= 8'h30) && (ch <= 8'h37);
        if (multi) begin
            bit_ok  = (ch == 8'h30) || (ch == 8'h31);
            bit_val = (ch == 8'h31);
        end else begin
            bit_ok  = (ch == 8'h50) || (ch == 8'h4E);
            bit_val = (ch == 8'h50);
        end
    end
endmodule

// File: rtl/pcl_colmap.sv
module pcl_colmap
    import pcl_pkg::*;
(
    input  logic       multi,
    input  logic [6:0] col,
    output colrole_t   role
);
    always_comb role = col_role(multi, col);
endmodule

// File: rtl/pcl_loader.sv
module pcl_loader
    import pcl_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fmt_multi,
    input  logic              ch_valid,
    input  logic              ch_eor,
    input  logic [7:0]        ch_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              err_char,
    output logic              err_range,
    output logic              err_octal,
    output logic [CNT_W-1:0]  wr_count
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int MAX_BLK = DEPTH - BLK_WORDS;

    logic [6:0]        col_q;
    logic              drop_q;
    logic [ACC_W-1:0]  acc_q, acc_base, acc_nx;
    logic [ADDR_W-1:0] base_q;
    logic [WORD_W-1:0] word_q, word_nx;
    logic [OCT_W-1:0]  oct_q, oct_base, oct_nx;
    colrole_t          role;
    logic              dig_ok, bit_ok, bit_val, oct_ok;
    logic [3:0]        dig_val;
    logic              take, live, blk_bad, bad_oct, bad_rng;

    pcl_colmap u_colmap (.multi(fmt_multi), .col(col_q), .role(role));

    pcl_chardec u_chardec (
        .multi(fmt_multi), .ch(ch_data), .dig_ok(dig_ok), .dig_val(dig_val),
        .bit_ok(bit_ok), .bit_val(bit_val), .oct_ok(oct_ok)
    );

    always_comb begin
        take     = ch_valid && !ch_eor;
        live     = take && !drop_q && (role.kind != FK_SKIP);
        acc_base = role.first ? '0 : acc_q;
        acc_nx   = acc_base * ACC_W'(10) + ACC_W'(dig_val);
        blk_bad  = ((acc_nx % ACC_W'(BLK_WORDS)) != '0) || (acc_nx > ACC_W'(MAX_BLK));
        word_nx  = {word_q[WORD_W-2:0], bit_val};
        oct_base = role.first ? '0 : oct_q;
        oct_nx   = {oct_base[OCT_W-4:0], dig_val[2:0]};
        bad_oct  = oct_nx != OCT_W'(word_q);
        bad_rng  = acc_q > ACC_W'(DEPTH - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q     <= 7'd1;
            drop_q    <= 1'b0;
            acc_q     <= '0;
            base_q    <= '0;
            word_q    <= '0;
            oct_q     <= '0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            err_char  <= 1'b0;
            err_range <= 1'b0;
            err_octal <= 1'b0;
            wr_count  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ch_valid && ch_eor) begin
                col_q  <= 7'd1;
                drop_q <= 1'b0;
            end else if (take) begin
                if (int'(col_q) <= COLS) col_q <= col_q + 7'd1;
                if (live) begin
                    unique case (role.kind)
                        FK_ADDR: begin
                            if (!dig_ok) begin
                                err_char <= 1'b1;
                                drop_q   <= 1'b1;
                            end else begin
                                acc_q <= acc_nx;
                                if (role.last && !fmt_multi) begin
                                    if (blk_bad) begin
                                        err_range <= 1'b1;
                                        drop_q    <= 1'b1;
                                    end else begin
                                        base_q <= acc_nx[ADDR_W-1:0];
                                    end
                                end
                            end
                        end
                        FK_BITS: begin
                            if (!bit_ok) begin
                                err_char <= 1'b1;
                                drop_q   <= 1'b1;
                            end else begin
                                word_q <= word_nx;
                                if (role.last && !fmt_multi) begin
                                    wr_en    <= 1'b1;
                                    wr_addr  <= base_q + ADDR_W'(role.idx);
                                    wr_data  <= word_nx;
                                    wr_count <= wr_count + 1'b1;
                                end
                            end
                        end
                        FK_OCT: begin
                            if (!oct_ok) begin
                                err_char <= 1'b1;
                                drop_q   <= 1'b1;
                            end else begin
                                oct_q <= oct_nx;
                                if (role.last) begin
                                    if (bad_oct) err_octal <= 1'b1;
                                    if (bad_rng) err_range <= 1'b1;
                                    if (!bad_oct && !bad_rng) begin
                                        wr_en    <= 1'b1;
                                        wr_addr  <= acc_q[ADDR_W-1:0];
                                        wr_data  <= word_q;
                                        wr_count <= wr_count + 1'b1;
                                    end
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/pcl_loader_chk.sv
module pcl_loader_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             fmt_multi,
    input logic             ch_valid,
    input logic             wr_en,
    input logic             err_char,
    input logic             err_range,
    input logic             err_octal,
    input logic [CNT_W-1:0] wr_count
);
    p_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    p_count_step_r11: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_count == CNT_W'($past(wr_count) + 1'b1));

    p_count_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> $stable(wr_count));

    p_idle_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        !ch_valid |=> !wr_en);

    p_char_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        err_char |=> err_char);

    p_range_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        err_range |=> err_range);

    p_oct_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        err_octal |=> err_octal);

    p_oct_only_multi_r8: assert property (@(posedge clk) disable iff (rst)
        (!fmt_multi && !err_octal) |=> !err_octal);
endmodule

bind pcl_loader pcl_loader_chk #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst(rst), .fmt_multi(fmt_multi), .ch_valid(ch_valid),
    .wr_en(wr_en), .err_char(err_char), .err_range(err_range),
    .err_octal(err_octal), .wr_count(wr_count)
);

// File: tb/test_pcl_loader.sv
module test_pcl_loader;
    localparam int TB_CNT_W = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fmt_multi = 1'b0;
    logic       ch_valid = 1'b0;
    logic       ch_eor = 1'b0;
    logic [7:0] ch_data = 8'h00;
    logic       wr_en;
    logic [10:0] wr_addr;
    logic [7:0] wr_data;
    logic       err_char, err_range, err_octal;
    logic [TB_CNT_W-1:0] wr_count;

    pcl_loader #(.ADDR_W(11), .CNT_W(TB_CNT_W)) i_pcl_loader (
        .clk(clk), .rst(rst), .fmt_multi(fmt_multi), .ch_valid(ch_valid),
        .ch_eor(ch_eor), .ch_data(ch_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .err_char(err_char), .err_range(err_range),
        .err_octal(err_octal), .wr_count(wr_count)
    );

    always #4 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    int m_col, m_acc, m_base, m_word, m_oct, m_cnt;
    bit m_drop, m_ec, m_er, m_eo;
    bit e_wr;
    int e_addr, e_data;

    task automatic model_reset();
        m_col = 1; m_acc = 0; m_base = 0; m_word = 0; m_oct = 0; m_cnt = 0;
        m_drop = 0; m_ec = 0; m_er = 0; m_eo = 0; e_wr = 0; e_addr = 0; e_data = 0;
    endtask

    task automatic emit(int a, int d);
        e_wr = 1; e_addr = a; e_data = d;
        m_cnt = (m_cnt + 1) % (1 << TB_CNT_W);
    endtask

    task automatic model_step(bit v, bit e, byte c, bit multi);
        int col, p, d;
        e_wr = 0;
        if (!v) return;
        if (e) begin m_col = 1; m_drop = 0; return; end
        col = m_col;
        if (m_col <= 80) m_col++;
        if (m_drop || col > 80) return;
        d = int'(c) - 48;
        if (!multi) begin
            if (col <= 5) begin
                if (d < 0 || d > 9) begin m_ec = 1; m_drop = 1; return; end
                m_acc = (col == 1 ? 0 : m_acc) * 10 + d;
                if (col == 5) begin
                    if (m_acc % 8 != 0 || m_acc > 2040) begin m_er = 1; m_drop = 1; end
                    else m_base = m_acc;
                end
            end else if (col >= 7 && col <= 78 && (col - 7) % 9 < 8) begin
                if (c == "P") m_word = (m_word * 2 + 1) % 256;
                else if (c == "N") m_word = (m_word * 2) % 256;
                else begin m_ec = 1; m_drop = 1; return; end
                if ((col - 7) % 9 == 7) emit(m_base + (col - 7) / 9, m_word);
            end
        end else begin
            p = (col - 1) % 21;
            if (p < 4) begin
                if (d < 0 || d > 9) begin m_ec = 1; m_drop = 1; return; end
                m_acc = (p == 0 ? 0 : m_acc) * 10 + d;
            end else if (p >= 5 && p <= 12) begin
                if (d < 0 || d > 1) begin m_ec = 1; m_drop = 1; return; end
                m_word = (m_word * 2 + d) % 256;
            end else if (p >= 14 && p <= 16) begin
                if (d < 0 || d > 7) begin m_ec = 1; m_drop = 1; return; end
                m_oct = (p == 14 ? 0 : m_oct) * 8 + d;
                if (p == 16) begin
                    if (m_oct != m_word) m_eo = 1;
                    if (m_acc > 2047) m_er = 1;
                    if (m_oct == m_word && m_acc <= 2047) emit(m_acc, m_word);
                end
            end
        end
    endtask

    task automatic compare(string tag);
        n_vec++;
        if (wr_en !== e_wr) begin
            n_bad++; $display("FAIL %s wr_en actual=%0b expected=%0b", tag, wr_en, e_wr);
        end else if (e_wr && (int'(wr_addr) != e_addr || int'(wr_data) != e_data)) begin
            n_bad++; $display("FAIL %s write actual=%0d:%02h expected=%0d:%02h",
                              tag, wr_addr, wr_data, e_addr, e_data);
        end
        if ({err_char, err_range, err_octal} !== {m_ec, m_er, m_eo}) begin
            n_bad++; $display("FAIL %s flags actual=%b expected=%b", tag,
                              {err_char, err_range, err_octal}, {m_ec, m_er, m_eo});
        end
        if (int'(wr_count) != m_cnt) begin
            n_bad++; $display("FAIL %s wr_count actual=%0d expected=%0d", tag, wr_count, m_cnt);
        end
    endtask

    task automatic tick(bit v, bit e, byte c, string tag);
        ch_valid = v; ch_eor = e; ch_data = c;
        model_step(v, e, c, fmt_multi);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1; ch_valid = 0; ch_eor = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        model_reset();
        compare("R1");
        rst = 0;
    endtask

    task automatic send_rec(string s, bit multi, string tag, int gap);
        fmt_multi = multi;
        for (int i = 0; i < s.len(); i++) begin
            tick(1, 0, s[i], tag);
            for (int g = 0; g < gap; g++) tick(0, 0, 8'h00, tag);
        end
        tick(1, 1, 8'h5A, tag);
    endtask

    function automatic string blk_rec(int start, int salt, string tail);
        string s;
        int w;
        s = $sformatf("%05d ", start);
        for (int k = 0; k < 8; k++) begin
            w = (salt * 53 + k * 29 + 17) % 256;
            for (int b = 7; b >= 0; b--) s = {s, w[b] ? "P" : "N"};
            s = {s, " "};
        end
        return {s, tail};
    endfunction

    function automatic string mul_grp(int a, int w, int o);
        return $sformatf("%04d %08b %03o    ", a, w[7:0], o[8:0]);
    endfunction

    initial begin
        string s;
        do_reset();                                              // R1
        send_rec(blk_rec(0, 1, "  "), 0, "R3/R4", 0);            // R3 R4
        send_rec(blk_rec(2040, 2, "ZQ"), 0, "R6/R4", 0);         // R6 boundary start
        s = blk_rec(512, 3, "  "); s.putc(5, "#"); s.putc(77, "x");
        send_rec(s, 0, "R6", 0);                                 // R6 separators
        send_rec(blk_rec(1000, 4, "  "), 0, "R2", 1);            // R2 idle gaps
        s = blk_rec(64, 5, "  ");
        send_rec(s.substr(0, 30), 0, "R2", 0);                   // R2 short record
        send_rec({blk_rec(72, 6, "  "), "PPNN"}, 0, "R2", 0);    // R2 past column 80
        send_rec({mul_grp(0, 165, 165), mul_grp(2047, 60, 60),
                  mul_grp(5, 255, 255), mul_grp(1234, 0, 0)}, 1, "R7", 0);
        for (int k = 0; k < 8; k++)
            send_rec(blk_rec(128 + 8 * k, 10 + k, "  "), 0, "R11", 0);
        tick(0, 0, 8'h00, "R12");
        send_rec({mul_grp(10, 7, 7), mul_grp(11, 200, 201),
                  mul_grp(12, 9, 9), mul_grp(13, 1, 1)}, 1, "R8", 0);
        tick(0, 0, 8'h00, "R12");
        do_reset();
        send_rec({mul_grp(20, 3, 3), mul_grp(3000, 4, 4),
                  mul_grp(21, 5, 5), mul_grp(2048, 6, 6)}, 1, "R9", 0);
        do_reset();
        send_rec(blk_rec(13, 7, "  "), 0, "R5", 0);
        do_reset();
        send_rec(blk_rec(2048, 8, "  "), 0, "R5", 0);
        do_reset();
        s = blk_rec(256, 9, "  "); s.putc(35, "Q");
        send_rec(s, 0, "R10", 0);
        send_rec(blk_rec(264, 9, "  "), 0, "R10", 0);
        do_reset();
        s = blk_rec(256, 9, "  "); s.putc(2, "A");
        send_rec(s, 0, "R10", 0);
        do_reset();
        s = {mul_grp(30, 17, 17), mul_grp(31, 18, 18), mul_grp(32, 19, 19), mul_grp(33, 20, 20)};
        s.putc(29, "2");
        send_rec(s, 1, "R10", 0);
        do_reset();
        s = {mul_grp(40, 63, 63), mul_grp(41, 64, 64), mul_grp(42, 65, 65), mul_grp(43, 66, 66)};
        s.putc(36, "8");
        send_rec(s, 1, "R10", 0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule